// File: doc/BRIEF.md
# Receive Idle Timeout Detector

This block sits beside a UART receiver and flags a receive line that has gone quiet while unread data is still waiting. Each character written into the receive FIFO arms the detector and restarts its count. From then on, every bit-interval tick from the baud generator moves the count forward. When the programmed number of whole character times has passed with no new character, a sticky status bit is set and the interrupt request is raised.

One character time is not a fixed number of bits. It is worked out on every tick from the live frame format: start bit, data length, optional parity and one or two stop bits. Because the count only moves on bit ticks, the delay in absolute time grows as the baud rate falls. Software clears the status bit with a read-clear strobe. The detector then stays silent until another character arrives. A programmed timeout of zero turns the function off.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `timeout_status` and `irq` are both 0, and they stay 0 until a character has been received.
- R2: One character time is 1 + D + P + S bit ticks. D = 5 + `data_len`, where `data_len` codes 0, 1, 2 and 3 mean 5, 6, 7 and 8 data bits. P = `parity_en`. S = 1 + `stop_two`. This gives a range of 7 to 12 ticks.
- R3: Let the timeout value be N and the character time be L. `timeout_status` becomes 1 at the clock edge that samples the (N×L)-th `bit_tick` counted after the last `rx_char`. Ticks are counted only in cycles after the `rx_char` cycle. One tick earlier, `timeout_status` is still 0.
- R4: Each `rx_char` pulse restarts the count from zero. A `bit_tick` in the same cycle as `rx_char` is not counted.
- R5: While `fifo_empty` is 1, the count is held at zero and ticks are ignored. Once `fifo_empty` returns to 0, the count starts again from zero and a full N×L ticks is needed.
- R6: With `timeout_val` = 0, `timeout_status` never becomes 1.
- R7: Once set, `timeout_status` stays 1 until a cycle with `status_clr` = 1. It reads 0 from the edge that samples that strobe.
- R8: After an expiry, no further expiry occurs until a new `rx_char` arrives, however many ticks follow.
- R9: If `status_clr` and an expiry fall in the same cycle, the expiry wins and `timeout_status` is 1 afterwards.
- R10: `irq` always equals `timeout_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit interval from the baud generator |
| rx_char | input | 1 | One-cycle pulse per character written into the receive FIFO |
| fifo_empty | input | 1 | Receive FIFO empty flag |
| data_len | input | 2 | Data length code (0..3 meaning 5..8 data bits) |
| parity_en | input | 1 | Parity bit present in the frame |
| stop_two | input | 1 | Two stop bits when 1, one stop bit when 0 |
| timeout_val | input | 8 | Timeout in character times; 0 disables the function |
| status_clr | input | 1 | Read-clear strobe for the status bit |
| timeout_status | output | 1 | Sticky receive-timeout status bit |
| irq | output | 1 | Interrupt request |

## Verification
The two events that can collide are the read-clear strobe and the expiring tick. Software may clear the bit in exactly the cycle in which a fresh expiry is due. The bench first leaves the status bit set from an earlier expiry, so that a winning clear would be visible. It then re-arms with a new character and counts N×L−1 ticks, and drives the last tick and `status_clr` together in one cycle. The status bit must read 1 after that edge; the next lone clear must bring it to 0. A second collision, a character arriving together with a tick, is judged by requiring a full N×L further ticks before the expiry.

// File: rtl/rto_pkg.sv
package rto_pkg;

   // Length of one serial character in bit ticks:
   // start bit + data bits + optional parity + stop bits.
   function automatic int unsigned char_ticks(input int unsigned min_data,
                                              input int unsigned len_code,
                                              input int unsigned parity,
                                              input int unsigned extra_stop);
      return 1 + min_data + len_code + parity + 1 + extra_stop;
   endfunction

   // Longest character the format fields can select.
   function automatic int unsigned max_char_ticks(input int unsigned min_data,
                                                  input int unsigned code_w);
      return char_ticks(min_data, (1 << code_w) - 1, 1, 1);
   endfunction

   // Shortest character the format fields can select.
   function automatic int unsigned min_char_ticks(input int unsigned min_data);
      return char_ticks(min_data, 0, 0, 0);
   endfunction

endpackage

// File: rtl/rto_frame_len.sv
module rto_frame_len
   import rto_pkg::*;
#(
   parameter int unsigned MIN_DATA = 5,
   parameter int unsigned DLEN_W   = 2,
   parameter int unsigned LEN_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DLEN_W-1:0] data_len,
   input  logic              parity_en,
   input  logic              stop_two,
   output logic [LEN_W-1:0]  frame_len
);

   localparam int unsigned MAX_LEN = max_char_ticks(MIN_DATA, DLEN_W);
   localparam int unsigned MIN_LEN = min_char_ticks(MIN_DATA);
   localparam int unsigned FIXED   = 2 + MIN_DATA;

   generate
      if ((1 << LEN_W) <= MAX_LEN) begin : g_bad_width
         $error("rto_frame_len: LEN_W too small for the longest character");
      end
   endgenerate

   always_comb begin
      frame_len = LEN_W'(FIXED) + LEN_W'(data_len) + LEN_W'(parity_en) + LEN_W'(stop_two);
   end

   AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(frame_len) >= MIN_LEN) && (int'(frame_len) <= MAX_LEN)); // R2

endmodule

// File: rtl/rto_bit_timer.sv
module rto_bit_timer #(
   parameter int unsigned LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             restart,
   input  logic             run,
   input  logic [LEN_W-1:0] frame_len,
   output logic             char_wrap
);

   logic [LEN_W-1:0] bit_cnt;
   logic             at_end;

   // A greater-or-equal test lets a shortened format take effect mid-character.
   always_comb begin
      at_end    = ({1'b0, bit_cnt} + {{LEN_W{1'b0}}, 1'b1}) >= {1'b0, frame_len};
      char_wrap = run & ~restart & bit_tick & at_end;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
      end else if (restart || !run) begin
         bit_cnt <= '0;
      end else if (bit_tick) begin
         if (at_end) bit_cnt <= '0;
         else        bit_cnt <= bit_cnt + 1'b1;
      end
   end

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (bit_cnt == '0)); // R4

   AST_NO_TICK_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |-> !char_wrap); // R3

endmodule

// File: rtl/rto_char_count.sv
module rto_char_count #(
   parameter int unsigned TO_W       = 8,
   parameter bit          COUNT_DOWN = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            run,
   input  logic            char_wrap,
   input  logic [TO_W-1:0] limit,
   output logic            expire
);

   generate
      if (TO_W < 1 || TO_W > 16) begin : g_bad_to_w
         $error("rto_char_count: TO_W must lie in 1..16");
      end

      if (COUNT_DOWN) begin : g_down
         // Remaining characters, loaded while idle or on restart.
         logic [TO_W-1:0] remain;

         always_comb begin
            expire = char_wrap & (remain <= TO_W'(1));
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               remain <= '0;
            end else if (restart || !run) begin
               remain <= limit;
            end else if (char_wrap) begin
               remain <= remain - 1'b1;
            end
         end
      end else begin : g_up
         // Elapsed characters, compared against the live limit.
         logic [TO_W-1:0] elapsed;

         always_comb begin
            expire = char_wrap &
                     (({1'b0, elapsed} + {{TO_W{1'b0}}, 1'b1}) >= {1'b0, limit});
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               elapsed <= '0;
            end else if (restart || !run) begin
               elapsed <= '0;
            end else if (char_wrap) begin
               if (expire) elapsed <= '0;
               else        elapsed <= elapsed + 1'b1;
            end
         end
      end
   endgenerate

   AST_EXPIRE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> char_wrap); // R3

endmodule

// File: rtl/rto_status.sv
module rto_status (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_char,
   input  logic expire,
   input  logic status_clr,
   output logic armed,
   output logic status
);

   // Armed from a received character until the following expiry.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed <= 1'b0;
      else if (rx_char) armed <= 1'b1;
      else if (expire)  armed <= 1'b0;
   end

   // Sticky status bit; a new expiry outranks the clear strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          status <= 1'b0;
      else if (expire)     status <= 1'b1;
      else if (status_clr) status <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> status); // R9

   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (status_clr && !expire) |=> !status); // R7

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !status_clr) |=> status); // R7

   AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !rx_char) |=> !expire); // R8

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
   import rto_pkg::*;
#(
   parameter int unsigned TO_W       = 8,
   parameter int unsigned DLEN_W     = 2,
   parameter int unsigned MIN_DATA   = 5,
   parameter bit          COUNT_DOWN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              rx_char,
   input  logic              fifo_empty,
   input  logic [DLEN_W-1:0] data_len,
   input  logic              parity_en,
   input  logic              stop_two,
   input  logic [TO_W-1:0]   timeout_val,
   input  logic              status_clr,
   output logic              timeout_status,
   output logic              irq
);

   localparam int unsigned MAX_LEN = max_char_ticks(MIN_DATA, DLEN_W);
   localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

   generate
      if (MIN_DATA < 1 || MIN_DATA > 16) begin : g_bad_min
         $error("rx_idle_timeout: MIN_DATA must lie in 1..16");
      end
      if (DLEN_W < 1 || DLEN_W > 4) begin : g_bad_dlen
         $error("rx_idle_timeout: DLEN_W must lie in 1..4");
      end
   endgenerate

   logic [LEN_W-1:0] frame_len;
   logic             armed;
   logic             run;
   logic             char_wrap;
   logic             expire;

   always_comb begin
      run = armed & ~fifo_empty & (timeout_val != '0);
   end

   rto_frame_len #(
      .MIN_DATA (MIN_DATA),
      .DLEN_W   (DLEN_W),
      .LEN_W    (LEN_W)
   ) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_len  (data_len),
      .parity_en (parity_en),
      .stop_two  (stop_two),
      .frame_len (frame_len)
   );

   rto_bit_timer #(
      .LEN_W (LEN_W)
   ) u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .restart   (rx_char),
      .run       (run),
      .frame_len (frame_len),
      .char_wrap (char_wrap)
   );

   rto_char_count #(
      .TO_W       (TO_W),
      .COUNT_DOWN (COUNT_DOWN)
   ) u_chars (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (rx_char),
      .run       (run),
      .char_wrap (char_wrap),
      .limit     (timeout_val),
      .expire    (expire)
   );

   rto_status u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_char    (rx_char),
      .expire     (expire),
      .status_clr (status_clr),
      .armed      (armed),
      .status     (timeout_status)
   );

   always_comb begin
      irq = timeout_status;
   end

   AST_EMPTY_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !expire); // R5

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((timeout_val == '0) && !timeout_status) |=> !timeout_status); // R6

   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      irq == timeout_status); // R10

endmodule

// File: tb/sim_rx_idle_timeout.sv
`timescale 1ns/1ps
module sim_rx_idle_timeout;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       rx_char = 1'b0;
   logic       fifo_empty = 1'b0;
   logic [1:0] data_len = 2'd0;
   logic       parity_en = 1'b0;
   logic       stop_two = 1'b0;
   logic [7:0] timeout_val = 8'd0;
   logic       status_clr = 1'b0;
   logic       timeout_status;
   logic       irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   rx_idle_timeout u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .bit_tick       (bit_tick),
      .rx_char        (rx_char),
      .fifo_empty     (fifo_empty),
      .data_len       (data_len),
      .parity_en      (parity_en),
      .stop_two       (stop_two),
      .timeout_val    (timeout_val),
      .status_clr     (status_clr),
      .timeout_status (timeout_status),
      .irq            (irq)
   );

   // One clock cycle with the given strobes; inputs change 1 ns after the edge.
   task automatic step(input logic t, input logic r, input logic c);
      bit_tick   = t;
      rx_char    = r;
      status_clr = c;
      @(posedge clk);
      #1;
      bit_tick   = 1'b0;
      rx_char    = 1'b0;
      status_clr = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   function automatic int frame(input int code, input int par, input int st);
      return 1 + 5 + code + par + 1 + st;
   endfunction

   task automatic set_fmt(input int code, input int par, input int st);
      data_len  = code[1:0];
      parity_en = par[0];
      stop_two  = st[0];
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      int len;
      #12;
      rst_n = 1'b1;
      #1;
      chk("R1 status after reset", timeout_status, 1'b0);
      chk("R1 irq after reset", irq, 1'b0);
      timeout_val = 8'd2;
      ticks(40);
      chk("R1 no character yet", timeout_status, 1'b0);

      // R2 / R3 / R8 / R10 sweep over every frame format.
      for (int code = 0; code < 4; code++) begin
         for (int par = 0; par < 2; par++) begin
            for (int st = 0; st < 2; st++) begin
               n   = 1 + ((code * 4 + par * 2 + st) % 3);
               len = frame(code, par, st);
               set_fmt(code, par, st);
               timeout_val = n[7:0];
               step(1'b0, 1'b1, 1'b0);
               ticks(n * len - 1);
               chk("R2 one tick short", timeout_status, 1'b0);
               ticks(1);
               chk("R3 expiry on last tick", timeout_status, 1'b1);
               chk("R10 irq follows", irq, 1'b1);
               step(1'b0, 1'b0, 1'b1);
               chk("R7 clear", timeout_status, 1'b0);
               ticks(3 * len);
               chk("R8 no refire", timeout_status, 1'b0);
            end
         end
      end

      // R7 sticky with and without ticks.
      set_fmt(3, 1, 1);
      len = 12;
      n = 4;
      timeout_val = 8'd4;
      step(1'b0, 1'b1, 1'b0);
      ticks(n * len);
      chk("R3 expiry 8N1P2", timeout_status, 1'b1);
      for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0);
      chk("R7 sticky idle", timeout_status, 1'b1);
      ticks(100);
      chk("R7 sticky ticking", timeout_status, 1'b1);
      step(1'b0, 1'b0, 1'b1);
      chk("R7 clear after sticky", timeout_status, 1'b0);

      // R4 restart by a later character.
      step(1'b0, 1'b1, 1'b0);
      ticks(n * len - 3);
      step(1'b0, 1'b1, 1'b0);
      ticks(n * len - 1);
      chk("R4 restart short", timeout_status, 1'b0);
      ticks(1);
      chk("R4 restart expiry", timeout_status, 1'b1);
      step(1'b0, 1'b0, 1'b1);

      // R4 character together with a tick: that tick is not counted.
      step(1'b0, 1'b1, 1'b0);
      ticks(5);
      step(1'b1, 1'b1, 1'b0);
      ticks(n * len - 1);
      chk("R4 coincident short", timeout_status, 1'b0);
      ticks(1);
      chk("R4 coincident expiry", timeout_status, 1'b1);
      step(1'b0, 1'b0, 1'b1);

      // R5 empty FIFO holds the count at zero.
      step(1'b0, 1'b1, 1'b0);
      ticks(20);
      fifo_empty = 1'b1;
      ticks(200);
      chk("R5 empty no fire", timeout_status, 1'b0);
      fifo_empty = 1'b0;
      ticks(n * len - 1);
      chk("R5 resume from zero", timeout_status, 1'b0);
      ticks(1);
      chk("R5 expiry after resume", timeout_status, 1'b1);
      step(1'b0, 1'b0, 1'b1);

      // R6 disabled.
      timeout_val = 8'd0;
      step(1'b0, 1'b1, 1'b0);
      ticks(3000);
      chk("R6 disabled", timeout_status, 1'b0);

      // R3 largest timeout with shortest frame.
      set_fmt(0, 0, 0);
      len = 7;
      timeout_val = 8'd255;
      step(1'b0, 1'b1, 1'b0);
      ticks(255 * len - 1);
      chk("R3 max short", timeout_status, 1'b0);
      ticks(1);
      chk("R3 max expiry", timeout_status, 1'b1);

      // R9 clear and expiry in the same cycle; status is already set.
      timeout_val = 8'd2;
      step(1'b0, 1'b1, 1'b0);
      ticks(2 * len - 1);
      chk("R9 still set before", timeout_status, 1'b1);
      step(1'b1, 1'b0, 1'b1);
      chk("R9 set wins", timeout_status, 1'b1);
      chk("R10 irq on collision", irq, 1'b1);
      step(1'b0, 1'b0, 1'b1);
      chk("R9 later clear", timeout_status, 1'b0);
      chk("R10 irq cleared", irq, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule